// File: doc/BRIEF.md
# Receive Sample Packet Framer

The framer sits between a tagged sample queue and a 36-bit word stream. Each queue entry carries one multi-channel sample, a 64-bit timestamp (seconds in the upper half, ticks in the lower half), an end-of-burst tag and an error tag. The block gathers samples into a local buffer. It closes a packet when the programmed sample count is reached or when an end-of-burst tag arrives. It then sends the packet as a header word, the stream identifier, the seconds and ticks of the packet's first sample, the payload and a closing word. The header's length field is filled in from the actual size of the packet.

An entry tagged as an error becomes a short error packet. Its final word carries both the start and the end flag, and downstream logic reads that pair as an error marker. If samples are still being gathered when the error entry arrives, they are first sent as their own packet. All programmable values arrive on a simple strobe/address/data settings bus that the block shares with its neighbours. The packet sequence number is placed in every header.

Top module: `rx_pkt_framer`

## Requirements
- R1: A settings write loads the header template at address BASE+4, the stream identifier at BASE+5, the closing word at BASE+6, the samples-per-packet count at BASE+7 and the channels-per-sample count at BASE+8. Writes to any other address change nothing in the output.
- R2: A normal packet is sent in this order: header (bit 32 set), stream identifier, seconds, ticks, payload, closing word (bit 33 set). The payload is sample by sample, and within a sample channel 0 (entry bits 31:0) comes first, then channel 1 (bits 63:32), and so on. Bits 35:34 are always zero.
- R3: Header bits 15:0 hold the total number of words in the packet: 5 plus samples times channels. Bits 31:20 are copied from the template.
- R4: Header bits 19:16 hold a sequence number that starts at 0 after reset. It increases by one, modulo 16, with every packet sent, error packets included.
- R5: A packet is closed once it holds the programmed number of samples. A programmed value of 0, or one above MAX_SPP, acts as MAX_SPP. A long burst is therefore split into full packets and a shorter final one.
- R6: An entry with its end-of-burst tag (entry bit 32·NCH+64) set closes the packet after that sample, even if the packet is short.
- R7: Each sample contributes as many payload words as the programmed channel count. A value of 0, or one above NCH, acts as NCH.
- R8: The seconds word (entry bits 32·NCH+63 to 32·NCH+32) and the ticks word (entry bits 32·NCH+31 to 32·NCH) of a packet come from that packet's first sample.
- R9: An entry with its error tag (entry bit 32·NCH+65) set produces a five-word packet: a header with length 5, the stream identifier, the error entry's seconds and ticks, and the closing word with bits 32 and 33 both set. Samples gathered before it are first sent as their own normal packet.
- R10: A word moves only on a cycle where out_valid and out_ready are both high. While the word is stalled, out_word holds steady.
- R11: in_ready is high only while the block is gathering samples. It is never high in a cycle where out_valid is high.
- R12: The synchronous clear input discards any partly gathered packet and returns the sequence number to 0.
- R13: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| clear | input | 1 | Synchronous abort and sequence restart |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings address |
| cfg_data | input | 32 | Settings data |
| in_data | input | 32·NCH+66 | Queue entry: samples, ticks, seconds, end-of-burst tag, error tag |
| in_valid | input | 1 | Queue entry present |
| in_ready | output | 1 | Entry taken this cycle when in_valid is high |
| out_word | output | 36 | Output word: data in 31:0, start flag in 32, end flag in 33 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink accepts the word |

## Verification
The assertions assume three things about the inputs. Settings are written only while no packet is being gathered or sent. The sink may drop out_ready at any cycle. Clear is pulsed only when no output packet is in flight, and the checks are suspended in the cycle of the pulse. The stimulus follows these rules: it writes settings and pulses clear only after every expected word has been received and out_valid is low. Throughout the run, the sink's ready follows a fixed irregular stall pattern, so every output state sees both stalled and moving cycles.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_GATHER, ST_HDR, ST_SID, ST_SEC, ST_TIC, ST_PAY, ST_TRL, ST_ERR
  } fr_state_t;

  // settings offsets relative to the block's base address
  localparam int unsigned OFS_HDR  = 4;
  localparam int unsigned OFS_SID  = 5;
  localparam int unsigned OFS_TRL  = 6;
  localparam int unsigned OFS_SPP  = 7;
  localparam int unsigned OFS_VLEN = 8;

  // header, stream id, seconds, ticks, closing word
  localparam int unsigned FIXED_WORDS = 5;
  localparam int unsigned SEQ_W       = 4;
endpackage

// File: rtl/rxf_cfg.sv
`timescale 1ns/1ps
module rxf_cfg
  import rxf_pkg::*;
#(
  parameter  int BASE    = 0,
  parameter  int MAX_SPP = 16,
  parameter  int NCH     = 2,
  localparam int SPP_W   = $clog2(MAX_SPP + 1),
  localparam int VL_W    = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_stb,
  input  logic [7:0]       cfg_addr,
  input  logic [31:0]      cfg_data,
  output logic [31:0]      hdr_tpl,
  output logic [31:0]      sid,
  output logic [31:0]      trl,
  output logic [SPP_W-1:0] spp_eff,
  output logic [VL_W-1:0]  vlen_eff
);
  logic [31:0] hdr_q, sid_q, trl_q, spp_q, vl_q;
  logic        en_hdr, en_sid, en_trl, en_spp, en_vl;

  always_comb begin
    en_hdr = cfg_stb && (cfg_addr == 8'(BASE + OFS_HDR));
    en_sid = cfg_stb && (cfg_addr == 8'(BASE + OFS_SID));
    en_trl = cfg_stb && (cfg_addr == 8'(BASE + OFS_TRL));
    en_spp = cfg_stb && (cfg_addr == 8'(BASE + OFS_SPP));
    en_vl  = cfg_stb && (cfg_addr == 8'(BASE + OFS_VLEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      sid_q <= '0;
      trl_q <= '0;
      spp_q <= '0;
      vl_q  <= '0;
    end else begin
      if (en_hdr) hdr_q <= cfg_data;
      if (en_sid) sid_q <= cfg_data;
      if (en_trl) trl_q <= cfg_data;
      if (en_spp) spp_q <= cfg_data;
      if (en_vl)  vl_q  <= cfg_data;
    end
  end

  always_comb begin
    hdr_tpl = hdr_q;
    sid     = sid_q;
    trl     = trl_q;
    if (spp_q == 32'd0 || spp_q > 32'(MAX_SPP)) spp_eff = SPP_W'(MAX_SPP);
    else                                        spp_eff = spp_q[SPP_W-1:0];
    if (vl_q == 32'd0 || vl_q > 32'(NCH))       vlen_eff = VL_W'(NCH);
    else                                        vlen_eff = vl_q[VL_W-1:0];
  end
endmodule

// File: rtl/rxf_buf.sv
`timescale 1ns/1ps
module rxf_buf #(
  parameter  int DW    = 64,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rxf_ctl.sv
`timescale 1ns/1ps
module rxf_ctl
  import rxf_pkg::*;
#(
  parameter  int MAX_SPP = 16,
  parameter  int NCH     = 2,
  localparam int SPP_W   = $clog2(MAX_SPP + 1),
  localparam int VL_W    = $clog2(NCH + 1),
  localparam int IDX_W   = $clog2(MAX_SPP),
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW      = 32 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [31:0]      hdr_tpl,
  input  logic [31:0]      sid,
  input  logic [31:0]      trl,
  input  logic [SPP_W-1:0] spp_eff,
  input  logic [VL_W-1:0]  vlen_eff,
  input  logic             in_valid,
  input  logic             in_err,
  input  logic             in_eob,
  input  logic [63:0]      in_ts,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [SW-1:0]    rd_data,
  output logic [35:0]      out_word,
  output logic             out_valid,
  input  logic             out_ready
);
  fr_state_t        state_q, state_n;
  logic [SPP_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] rs_q, rs_n;
  logic [CH_W-1:0]  rc_q, rc_n;
  logic [VL_W-1:0]  vl_q, vl_n;
  logic [63:0]      ts_q, ts_n, tse_q, tse_n;
  logic             errp_q, errp_n, emode_q, emode_n;
  logic [SEQ_W-1:0] seq_q, seq_n;

  logic             acc, xfer, last_chan, last_samp;
  logic [15:0]      pkt_len;
  logic [31:0]      chan_word [NCH];
  logic [31:0]      dword;
  logic             sof, eof;

  // split the buffered sample into channel words
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    assign chan_word[k] = rd_data[32*k +: 32];
  end

  always_comb begin
    in_ready  = (state_q == ST_GATHER);
    out_valid = (state_q != ST_GATHER);
    acc       = in_valid && in_ready;
    xfer      = out_valid && out_ready;
    wr_en     = acc && !in_err;
    wr_idx    = cnt_q[IDX_W-1:0];
    rd_idx    = rs_q;
    last_chan = (VL_W'(rc_q) == vl_q - VL_W'(1));
    last_samp = (SPP_W'(rs_q) == cnt_q - SPP_W'(1));
    if (emode_q) pkt_len = 16'(FIXED_WORDS);
    else         pkt_len = 16'(FIXED_WORDS) + 16'(cnt_q) * 16'(vl_q);
  end

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    rs_n    = rs_q;
    rc_n    = rc_q;
    vl_n    = vl_q;
    ts_n    = ts_q;
    tse_n   = tse_q;
    errp_n  = errp_q;
    emode_n = emode_q;
    seq_n   = seq_q;
    unique case (state_q)
      ST_GATHER: begin
        if (acc) begin
          if (in_err) begin
            if (cnt_q == '0) begin
              emode_n = 1'b1;
              ts_n    = in_ts;
            end else begin
              errp_n  = 1'b1;
              tse_n   = in_ts;
            end
            state_n = ST_HDR;
          end else begin
            if (cnt_q == '0) begin
              ts_n = in_ts;
              vl_n = vlen_eff;
            end
            cnt_n = cnt_q + SPP_W'(1);
            if (in_eob || cnt_n >= spp_eff) state_n = ST_HDR;
          end
        end
      end
      ST_HDR: if (xfer) state_n = ST_SID;
      ST_SID: if (xfer) state_n = ST_SEC;
      ST_SEC: if (xfer) state_n = ST_TIC;
      ST_TIC: begin
        if (xfer) begin
          rs_n    = '0;
          rc_n    = '0;
          state_n = emode_q ? ST_ERR : ST_PAY;
        end
      end
      ST_PAY: begin
        if (xfer) begin
          if (last_chan) begin
            rc_n = '0;
            if (last_samp) state_n = ST_TRL;
            else           rs_n    = rs_q + IDX_W'(1);
          end else begin
            rc_n = rc_q + CH_W'(1);
          end
        end
      end
      ST_TRL, ST_ERR: begin
        if (xfer) begin
          seq_n = seq_q + SEQ_W'(1);
          cnt_n = '0;
          if (errp_q) begin
            errp_n  = 1'b0;
            emode_n = 1'b1;
            ts_n    = tse_q;
            state_n = ST_HDR;
          end else begin
            emode_n = 1'b0;
            state_n = ST_GATHER;
          end
        end
      end
      default: state_n = ST_GATHER;
    endcase
    if (clear) begin
      state_n = ST_GATHER;
      cnt_n   = '0;
      errp_n  = 1'b0;
      emode_n = 1'b0;
      seq_n   = '0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      cnt_q   <= '0;
      rs_q    <= '0;
      rc_q    <= '0;
      vl_q    <= VL_W'(1);
      ts_q    <= '0;
      tse_q   <= '0;
      errp_q  <= 1'b0;
      emode_q <= 1'b0;
      seq_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rs_q    <= rs_n;
      rc_q    <= rc_n;
      vl_q    <= vl_n;
      ts_q    <= ts_n;
      tse_q   <= tse_n;
      errp_q  <= errp_n;
      emode_q <= emode_n;
      seq_q   <= seq_n;
    end
  end

  // output word mux
  always_comb begin
    sof = 1'b0;
    eof = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        dword = {hdr_tpl[31:20], seq_q, pkt_len};
        sof   = 1'b1;
      end
      ST_SID: dword = sid;
      ST_SEC: dword = ts_q[63:32];
      ST_TIC: dword = ts_q[31:0];
      ST_PAY: dword = chan_word[rc_q];
      ST_TRL: begin
        dword = trl;
        eof   = 1'b1;
      end
      ST_ERR: begin
        dword = trl;
        sof   = 1'b1;
        eof   = 1'b1;
      end
      default: dword = '0;
    endcase
    out_word = {2'b00, eof, sof, dword};
  end
endmodule

// File: rtl/rx_pkt_framer.sv
`timescale 1ns/1ps
module rx_pkt_framer #(
  parameter  int BASE    = 0,
  parameter  int MAX_SPP = 16,
  parameter  int NCH     = 2,
  localparam int SW      = 32 * NCH,
  localparam int ENT_W   = SW + 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cfg_stb,
  input  logic [7:0]       cfg_addr,
  input  logic [31:0]      cfg_data,
  input  logic [ENT_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [35:0]      out_word,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int SPP_W = $clog2(MAX_SPP + 1);
  localparam int VL_W  = $clog2(NCH + 1);
  localparam int IDX_W = $clog2(MAX_SPP);

  logic [31:0]      hdr_tpl, sid, trl;
  logic [SPP_W-1:0] spp_eff;
  logic [VL_W-1:0]  vlen_eff;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [SW-1:0]    rd_data;

  rxf_cfg #(.BASE(BASE), .MAX_SPP(MAX_SPP), .NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hdr_tpl(hdr_tpl), .sid(sid), .trl(trl),
    .spp_eff(spp_eff), .vlen_eff(vlen_eff)
  );

  rxf_buf #(.DW(SW), .DEPTH(MAX_SPP)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_data[SW-1:0]),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  rxf_ctl #(.MAX_SPP(MAX_SPP), .NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .hdr_tpl(hdr_tpl), .sid(sid), .trl(trl),
    .spp_eff(spp_eff), .vlen_eff(vlen_eff),
    .in_valid(in_valid), .in_err(in_data[SW+65]), .in_eob(in_data[SW+64]),
    .in_ts(in_data[SW+63:SW]), .in_ready(in_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready)
  );
endmodule

// File: rtl/rxf_chk.sv
`timescale 1ns/1ps
module rxf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [35:0] out_word
);
  logic        xfer, sof, eof;
  logic        in_pkt, seq_seen;
  logic [15:0] wcnt, hlen;
  logic [3:0]  lseq;

  assign xfer = out_valid && out_ready;
  assign sof  = out_word[32];
  assign eof  = out_word[33];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      seq_seen <= 1'b0;
      wcnt     <= '0;
      hlen     <= '0;
      lseq     <= '0;
    end else if (clear) begin
      in_pkt   <= 1'b0;
      seq_seen <= 1'b0;
      wcnt     <= '0;
    end else if (xfer) begin
      if (sof && !eof) begin
        in_pkt   <= 1'b1;
        wcnt     <= 16'd1;
        hlen     <= out_word[15:0];
        lseq     <= out_word[19:16];
        seq_seen <= 1'b1;
      end else if (eof) begin
        in_pkt <= 1'b0;
        wcnt   <= '0;
      end else begin
        wcnt <= wcnt + 16'd1;
      end
    end
  end

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n || clear)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R10
  AST_PULL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n || clear)
    in_ready |-> !out_valid); // R11
  AST_HDR_OUTSIDE_PKT: assert property (@(posedge clk) disable iff (!rst_n || clear)
    xfer && sof && !eof |-> !in_pkt); // R2
  AST_LEN_FIELD: assert property (@(posedge clk) disable iff (!rst_n || clear)
    xfer && eof |-> in_pkt && (wcnt + 16'd1 == hlen)); // R3
  AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n || clear)
    xfer && sof && !eof && seq_seen |-> out_word[19:16] == lseq + 4'd1); // R4
  AST_ERR_SHORT: assert property (@(posedge clk) disable iff (!rst_n || clear)
    xfer && sof && eof |-> hlen == 16'd5); // R9
endmodule

bind rx_pkt_framer rxf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
);

// File: tb/rx_pkt_framer_test.sv
`timescale 1ns/1ps
module rx_pkt_framer_test;
  localparam int NCH     = 2;
  localparam int MAX_SPP = 16;
  localparam int SW      = 32 * NCH;
  localparam int ENT_W   = SW + 66;

  logic             clk;
  logic             rst_n;
  logic             clear;
  logic             cfg_stb;
  logic [7:0]       cfg_addr;
  logic [31:0]      cfg_data;
  logic [ENT_W-1:0] in_data;
  logic             in_valid;
  logic             in_ready;
  logic [35:0]      out_word;
  logic             out_valid;
  logic             out_ready;

  rx_pkt_framer #(.BASE(0), .MAX_SPP(MAX_SPP), .NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [35:0] exp_q [$];

  // reference copies of the settings
  logic [31:0] m_hdr = '0, m_sid = '0, m_trl = '0;
  int          m_spp  = MAX_SPP;
  int          m_vlen = NCH;
  int          m_seq  = 0;

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] smp(input int b, input int i, input int c);
    return {8'(c + 1), 8'(b), 16'(i)};
  endfunction

  function automatic logic [ENT_W-1:0] mk(input bit err, input bit eob, input int secs,
                                          input int tk, input int b, input int i);
    logic [ENT_W-1:0] e;
    e = '0;
    for (int c = 0; c < NCH; c++) e[32*c +: 32] = smp(b, i, c);
    e[SW +: 32]      = 32'(tk);
    e[SW+32 +: 32]   = 32'(secs);
    e[SW+64]         = eob;
    e[SW+65]         = err;
    return e;
  endfunction

  task automatic cfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_stb = 1'b1; cfg_addr = 8'(a); cfg_data = d;
    @(negedge clk);
    cfg_stb = 1'b0;
    case (a)
      4: m_hdr = d;
      5: m_sid = d;
      6: m_trl = d;
      7: m_spp  = (d == 0 || d > MAX_SPP) ? MAX_SPP : int'(d);
      8: m_vlen = (d == 0 || d > NCH) ? NCH : int'(d);
      default: ;
    endcase
  endtask

  task automatic push_hdr(input int len);
    exp_q.push_back({2'b00, 2'b01, m_hdr[31:20], 4'(m_seq), 16'(len)});
    exp_q.push_back({4'b0000, m_sid});
  endtask

  // normal packet: samples first..first+n-1 of burst b
  task automatic exp_pkt(input int first, input int n, input int b, input int secs, input int tb);
    push_hdr(5 + n * m_vlen);
    exp_q.push_back({4'b0000, 32'(secs)});
    exp_q.push_back({4'b0000, 32'(tb + first)});          // R8 first sample time
    for (int i = first; i < first + n; i++)
      for (int c = 0; c < m_vlen; c++)
        exp_q.push_back({4'b0000, smp(b, i, c)});
    exp_q.push_back({2'b00, 2'b10, m_trl});
    m_seq = (m_seq + 1) % 16;
  endtask

  task automatic exp_err(input int secs, input int tk);
    push_hdr(5);
    exp_q.push_back({4'b0000, 32'(secs)});
    exp_q.push_back({4'b0000, 32'(tk)});
    exp_q.push_back({2'b00, 2'b11, m_trl});
    m_seq = (m_seq + 1) % 16;
  endtask

  task automatic put_entry(input logic [ENT_W-1:0] e);
    bit rdy, taken;
    @(negedge clk);
    in_valid = 1'b1; in_data = e;
    taken = 0;
    while (!taken) begin
      rdy = in_ready;
      @(negedge clk);
      taken = rdy;
    end
    in_valid = 1'b0;
  endtask

  task automatic burst(input int n, input int b, input int secs, input int tb, input bit eob_last);
    int i, k;
    i = 0;
    while (i < n) begin
      k = (n - i < m_spp) ? n - i : m_spp;
      if (k == m_spp || eob_last) exp_pkt(i, k, b, secs, tb);
      i += k;
    end
    for (int j = 0; j < n; j++) put_entry(mk(1'b0, eob_last && j == n - 1, secs, tb + j, b, j));
  endtask

  task automatic drain;
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // sink and scoreboard monitor
  int          cyc = 0;
  bit          prev_stall = 0;
  logic [35:0] prev_word = '0;
  logic [35:0] e_w;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !((cyc % 5) == 2 || (cyc % 13) == 7);
      #1;
      if (rst_n) begin
        if (out_valid && in_ready) chk(1'b0, "R11", {35'd0, in_ready}, 36'd0);
        if (prev_stall) chk(out_valid && out_word == prev_word, "R10", out_word, prev_word);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", out_word, 36'd0);
          else begin
            e_w = exp_q.pop_front();
            chk(out_word == e_w, "R2/R3/R4 packet word", out_word, e_w);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = out_word;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; cfg_stb = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!out_valid, "R13 out_valid", {35'd0, out_valid}, 36'd0);
    chk(in_ready, "R13 in_ready", {35'd0, in_ready}, 36'd1);

    // R1 settings load; template bits 19:16 set to show they are replaced (R3)
    cfg(4, 32'hA5B7_FFFF);
    cfg(5, 32'hF00D_1234);
    cfg(6, 32'hE000_0001);
    cfg(7, 4);
    cfg(8, 1);

    burst(4, 1, 100, 1000, 1'b1);              // R5 exact fit
    drain();
    burst(10, 2, 101, 2000, 1'b1);             // R5 split 4,4,2; R6 short tail
    drain();
    cfg(7, 3); cfg(8, 0);                      // R7 zero channels -> NCH
    burst(7, 3, 102, 3000, 1'b1);              // 3,3,1 with two channels
    drain();
    cfg(8, 5);                                 // R7 too many -> NCH
    burst(2, 4, 103, 3500, 1'b1);              // R6 early close
    drain();
    cfg(8, 1);
    exp_err(104, 4000);                        // R9 error packet alone
    put_entry(mk(1'b1, 1'b0, 104, 4000, 0, 0));
    drain();
    cfg(7, 4);                                 // R9 partial then error
    burst(3, 5, 105, 5000, 1'b0);
    exp_pkt(0, 3, 5, 105, 5000);
    exp_err(106, 6000);
    put_entry(mk(1'b1, 1'b0, 106, 6000, 0, 0));
    drain();
    cfg(3, 32'h1111_1111);                     // R1 foreign addresses ignored
    cfg(9, 32'h2222_2222);
    burst(2, 6, 107, 7000, 1'b1);
    drain();
    cfg(7, 1);                                 // R4 sequence wraps past 15
    burst(6, 7, 108, 8000, 1'b1);
    drain();
    cfg(7, 0);                                 // R5 zero count -> MAX_SPP
    burst(20, 8, 109, 9000, 1'b1);
    drain();
    cfg(7, 4);                                 // R12 clear drops partial, seq restarts
    burst(2, 9, 110, 10000, 1'b0);
    drain();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    m_seq = 0;
    #2;
    chk(!out_valid && in_ready, "R12 idle after clear", {34'd0, out_valid, in_ready}, 36'd1);
    burst(1, 10, 111, 11000, 1'b1);
    drain();

    chk(exp_q.size() == 0, "R2 all words seen", 36'(exp_q.size()), 36'd0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule